// File: doc/BRIEF.md
# Dual-Mode Serial Clock Divider

This block derives the serial clock of a serial peripheral interface master from the module clock. Alongside the clock level it gives two single-cycle strobes: one on the edge that leaves the idle level and one on the edge that returns to it. A transfer engine can use these strobes directly as its shift and sample ticks.

The divide ratio comes from a 32-bit control word that holds two divisor fields. Bits 7:0 hold a linear divisor `n`, which gives a half-period of `n+1` module cycles. Bits 11:8 hold an exponent `m`, which gives a half-period of `2^m` module cycles. Bit 12 chooses between them: 1 selects the linear field and 0 selects the exponent field.

The divisor and the idle polarity are captured only while the enable input is low. Changing either in the middle of a burst therefore does not disturb the clock. While the enable input is low, the clock rests at the polarity level.

Top module: `spi_clk_div`

## Requirements
- R1: With bit 12 of `clk_ctl_i` set, the serial clock period is `2*(n+1)` module cycles, where `n` is `clk_ctl_i[7:0]`. With `n = 0`, `sclk_o` toggles every module cycle.
- R2: With bit 12 clear, the serial clock period is `2^(m+1)` module cycles, where `m` is `clk_ctl_i[11:8]`.
- R3: The field that bit 12 does not select, and bits 31:13, have no effect on the period.
- R4: On the clock edge after `en_i` is sampled low, `sclk_o` equals the `cpol_i` value sampled at that edge. No strobe is raised while the block is idle.
- R5: After `en_i` rises, the first leading strobe and the first change of `sclk_o` appear at the Hth edge that samples `en_i` high, where H is the full half-period length.
- R6: In each serial clock period there is exactly one `lead_o` pulse and one `trail_o` pulse, each one module cycle long. `lead_o` coincides with `sclk_o` leaving the idle level, and `trail_o` with its return. The two strobes are never high together.
- R7: Changes of `clk_ctl_i` or `cpol_i` while `en_i` is high have no effect until the next burst. The next burst uses the values present in the last idle cycle before it starts.
- R8: During reset, `sclk_o`, `lead_o` and `trail_o` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Module clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clk_ctl_i | input | 32 | Clock control word: [7:0] linear divisor, [11:8] exponent, [12] mode select (1 = linear) |
| en_i | input | 1 | Burst enable from the transfer engine |
| cpol_i | input | 1 | Idle level of the serial clock |
| sclk_o | output | 1 | Serial clock level |
| lead_o | output | 1 | One-cycle strobe on the edge leaving the idle level |
| trail_o | output | 1 | One-cycle strobe on the edge returning to the idle level |

## Verification
All outputs are registered. A strobe and its matching `sclk_o` change appear together, at the edge that completes a half-period. The first one appears at the Hth edge after `en_i` is seen high, and `sclk_o` returns to idle one edge after `en_i` is seen low. The bench changes inputs and samples outputs on the falling edge. It counts falling edges from the one where `en_i` is raised, so a count of H marks exactly the edge on which the strobe is due. While it waits for the next strobe, it also checks that no other strobe appears and that `sclk_o` holds its level. Expected half-periods are computed as `n+1` or `1<<m` from the field values written.

// File: rtl/spi_clk_div_pkg.sv
package spi_clk_div_pkg;
  typedef enum logic {
    DIV_POW2 = 1'b0,
    DIV_LIN  = 1'b1
  } div_mode_e;
endpackage

// File: rtl/spi_clk_div_sel.sv
// Decodes the control word into (half-period - 1).
module spi_clk_div_sel
  import spi_clk_div_pkg::*;
#(
  parameter int unsigned CTL_W   = 32,
  parameter int unsigned LIN_W   = 8,
  parameter int unsigned EXP_W   = 4,
  parameter int unsigned SEL_POS = 12,
  parameter int unsigned CNT_W   = 16
) (
  input  logic [CTL_W-1:0] ctl_i,
  output logic [CNT_W-1:0] lim_o
);
  localparam int unsigned EXP_LSB = LIN_W;

  logic [LIN_W-1:0] lin_div;
  logic [EXP_W-1:0] exp_div;
  logic [CNT_W-1:0] therm;
  div_mode_e        mode;
  logic             unused_hi;

  assign lin_div   = ctl_i[LIN_W-1:0];
  assign exp_div   = ctl_i[EXP_LSB+EXP_W-1:EXP_LSB];
  assign mode      = div_mode_e'(ctl_i[SEL_POS]);
  assign unused_hi = ^ctl_i[CTL_W-1:SEL_POS+1];

  // 2^m - 1 as a thermometer code
  for (genvar g = 0; g < CNT_W; g++) begin : g_therm
    assign therm[g] = (32'(exp_div) > g);
  end

  always_comb begin
    if (mode == DIV_LIN) lim_o = CNT_W'(lin_div);
    else                 lim_o = therm;
  end
endmodule

// File: rtl/spi_clk_div_cnt.sv
module spi_clk_div_cnt #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [CNT_W-1:0] lim_i,
  output logic             tick_o
);
  logic [CNT_W-1:0] cnt_q;

  assign tick_o = en_i && (cnt_q == lim_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (!en_i)  cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/spi_clk_div_phase.sv
module spi_clk_div_phase (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic tick_i,
  input  logic cpol_i,
  input  logic cpol_lat_i,
  output logic sclk_o,
  output logic lead_o,
  output logic trail_o
);
  logic phase_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= 1'b0;
      sclk_o  <= 1'b0;
      lead_o  <= 1'b0;
      trail_o <= 1'b0;
    end else if (!en_i) begin
      phase_q <= 1'b0;
      sclk_o  <= cpol_i;
      lead_o  <= 1'b0;
      trail_o <= 1'b0;
    end else if (tick_i) begin
      phase_q <= ~phase_q;
      sclk_o  <= cpol_lat_i ^ ~phase_q;
      lead_o  <= ~phase_q;
      trail_o <= phase_q;
    end else begin
      lead_o  <= 1'b0;
      trail_o <= 1'b0;
    end
  end
endmodule

// File: rtl/spi_clk_div.sv
module spi_clk_div #(
  parameter int unsigned CTL_W   = 32,
  parameter int unsigned LIN_W   = 8,
  parameter int unsigned EXP_W   = 4,
  parameter int unsigned SEL_POS = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CTL_W-1:0] clk_ctl_i,
  input  logic             en_i,
  input  logic             cpol_i,
  output logic             sclk_o,
  output logic             lead_o,
  output logic             trail_o
);
  localparam int unsigned EXP_CNT_W = 2 ** EXP_W;
  localparam int unsigned LIN_CNT_W = LIN_W + 1;
  localparam int unsigned CNT_W     = (EXP_CNT_W > LIN_CNT_W) ? EXP_CNT_W : LIN_CNT_W;

  logic [CNT_W-1:0] lim_d, lim_q;
  logic             cpol_q;
  logic             tick;

  spi_clk_div_sel #(
    .CTL_W(CTL_W), .LIN_W(LIN_W), .EXP_W(EXP_W), .SEL_POS(SEL_POS), .CNT_W(CNT_W)
  ) u_sel (
    .ctl_i (clk_ctl_i),
    .lim_o (lim_d)
  );

  // settings frozen for the whole burst
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lim_q  <= '0;
      cpol_q <= 1'b0;
    end else if (!en_i) begin
      lim_q  <= lim_d;
      cpol_q <= cpol_i;
    end
  end

  spi_clk_div_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en_i),
    .lim_i  (lim_q),
    .tick_o (tick)
  );

  spi_clk_div_phase u_phase (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (en_i),
    .tick_i     (tick),
    .cpol_i     (cpol_i),
    .cpol_lat_i (cpol_q),
    .sclk_o     (sclk_o),
    .lead_o     (lead_o),
    .trail_o    (trail_o)
  );
endmodule

// File: rtl/spi_clk_div_chk.sv
module spi_clk_div_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic en_i,
  input logic cpol_i,
  input logic sclk_o,
  input logic lead_o,
  input logic trail_o
);
  // R4
  idle_level_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (sclk_o == $past(cpol_i)) && !lead_o && !trail_o);

  // R6
  strobe_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(lead_o && trail_o));

  // R6
  lead_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lead_o |=> !lead_o);

  // R6
  strobe_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lead_o || trail_o) |-> (sclk_o != $past(sclk_o)));

  // R6
  edge_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(en_i) && (sclk_o != $past(sclk_o))) |-> (lead_o || trail_o));

  // R8
  always_comb begin
    if (!rst_ni) begin
      reset_out_chk: assert (!sclk_o && !lead_o && !trail_o);
    end
  end
endmodule

bind spi_clk_div spi_clk_div_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .en_i    (en_i),
  .cpol_i  (cpol_i),
  .sclk_o  (sclk_o),
  .lead_o  (lead_o),
  .trail_o (trail_o)
);

// File: tb/spi_clk_div_tb.sv
module spi_clk_div_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WDOG_CYC   = 195000;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] clk_ctl_i = '0;
  logic        en_i = 1'b0;
  logic        cpol_i = 1'b0;
  logic        sclk_o, lead_o, trail_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  spi_clk_div u_dut (
    .clk_i, .rst_ni, .clk_ctl_i, .en_i, .cpol_i, .sclk_o, .lead_o, .trail_o
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [31:0] lin_word(input int n, input int junk);
    return (32'(junk) << 13) | (32'(junk & 15) << 8) | 32'h1000 | 32'(n & 255);
  endfunction

  function automatic logic [31:0] pow_word(input int m, input int junk);
    return (32'(junk) << 13) | (32'(m & 15) << 8) | 32'(junk & 255);
  endfunction

  // waits for the wanted strobe; counts cycles, flags stray strobes or level changes
  task automatic await(input bit want_lead, input logic lvl, input int exp, input string req);
    int  n = 0;
    bit  stray = 1'b0;
    bit  hit = 1'b0;
    while (!hit && n <= exp + 2) begin
      @(negedge clk_i);
      n++;
      if (want_lead ? lead_o : trail_o) hit = 1'b1;
      else if (lead_o || trail_o || sclk_o != lvl) stray = 1'b1;
    end
    check(n == exp, req, n, exp);
    check(!stray, "R6 no stray strobe or level change", int'(stray), 0);
    check(sclk_o == ~lvl, "R6 level changes with strobe", int'(sclk_o), int'(~lvl));
  endtask

  task automatic run_case(input logic [31:0] ctl, input logic pol, input int h, input string req,
                          input bit full);
    en_i = 1'b0; clk_ctl_i = ctl; cpol_i = pol;
    repeat (3) @(negedge clk_i);
    check(sclk_o == pol && !lead_o && !trail_o, "R4 idle level", int'(sclk_o), int'(pol));
    en_i = 1'b1;
    await(1'b1, pol, h, "R5 first half-period");
    await(1'b0, ~pol, h, req);
    if (full) await(1'b1, pol, h, req);
    en_i = 1'b0;
    @(negedge clk_i);
  endtask

  initial begin
    repeat (WDOG_CYC) @(posedge clk_i);
    if (!done) begin
      check(1'b0, "watchdog", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk_i);
    // R8
    check(!sclk_o && !lead_o && !trail_o, "R8 reset outputs", int'({sclk_o, lead_o, trail_o}), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R1 named points and sweep
    run_case(lin_word(0, 0),   1'b0, 1,   "R1 n=0", 1'b1);
    run_case(lin_word(1, 0),   1'b1, 2,   "R1 n=1", 1'b1);
    run_case(lin_word(255, 0), 1'b0, 256, "R1 n=255", 1'b1);
    for (int n = 0; n < 24; n++) run_case(lin_word(n, 0), 1'(n), n + 1, "R1 sweep", 1'b1);

    // R2 named points and sweep
    run_case(pow_word(0, 0), 1'b0, 1, "R2 m=0", 1'b1);
    run_case(pow_word(3, 0), 1'b1, 8, "R2 m=3", 1'b1);
    for (int m = 0; m < 9; m++) run_case(pow_word(m, 0), 1'(m), 1 << m, "R2 sweep", 1'b1);

    // R3 unselected field and high bits full of junk
    run_case(lin_word(5, 32'h7FFFF), 1'b0, 6, "R3 junk in linear mode", 1'b1);
    run_case(pow_word(2, 32'h5A5A5), 1'b1, 4, "R3 junk in power mode", 1'b1);

    // R7 mid-burst change ignored, applied on next burst
    en_i = 1'b0; clk_ctl_i = lin_word(3, 0); cpol_i = 1'b0;
    repeat (2) @(negedge clk_i);
    en_i = 1'b1;
    @(negedge clk_i);
    clk_ctl_i = lin_word(0, 0); cpol_i = 1'b1;
    await(1'b1, 1'b0, 3, "R7 lead after change");
    await(1'b0, 1'b1, 4, "R7 half-period kept");
    await(1'b1, 1'b0, 4, "R7 polarity kept");
    en_i = 1'b0;
    @(negedge clk_i);
    check(sclk_o == 1'b1, "R7 new polarity at idle", int'(sclk_o), 1);
    en_i = 1'b1;
    await(1'b1, 1'b1, 1, "R7 new divisor first half");
    await(1'b0, 1'b0, 1, "R7 new divisor");

    // R4 drop enable mid-high-phase
    en_i = 1'b0; clk_ctl_i = lin_word(3, 0); cpol_i = 1'b1;
    repeat (2) @(negedge clk_i);
    en_i = 1'b1;
    repeat (5) @(negedge clk_i);
    check(sclk_o == 1'b0, "R4 active level before drop", int'(sclk_o), 0);
    en_i = 1'b0;
    @(negedge clk_i);
    check(sclk_o == 1'b1 && !lead_o && !trail_o, "R4 return to idle", int'(sclk_o), 1);

    // R2 longest divisor, first half plus one half
    run_case(pow_word(15, 0), 1'b0, 32768, "R2 m=15", 1'b0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule